// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer with APB Access

A bank of identical down-counters behind an APB slave port. Each channel has five word registers: a reload value, a readable live count, a three-bit control word, a read-to-clear acknowledge word and a masked status word. Channel `k` starts at byte offset `k*0x14`. A shared group of four words at 0xA0 through 0xAC returns the masked status of all channels, clears every channel on read, returns the raw status of all channels and returns a constant version word.

Software stops a channel, writes its reload value and then enables it. The count takes the reload value on the enable edge and then drops by one on every clock. In free-running mode the count continues from 0 to all ones. In periodic mode it reloads from the reload register. Each pass through zero sets a flag. That flag drives a per-channel interrupt line unless the channel is masked or disabled. For a timebase, software loads all ones and reads the inverted live count as elapsed ticks.

Top module: `apb_timer_bank`

## Requirements
- R1: Every APB transfer completes in its first access cycle: `pready_o` is always 1 and `pslverr_o` is always 0.
- R2: Channel `k` decodes byte offsets `k*0x14` + {0x00 reload, 0x04 live count, 0x08 control, 0x0C acknowledge, 0x10 status}. The reload register reads back what was last written. All registers reset to 0.
- R3: The enable bit is control bit 0. On its rising edge the live count takes the reload value on the following clock. After that it decrements by one per clock while enabled.
- R4: While disabled, a channel keeps its count and holds its interrupt line low.
- R5: Free-running mode (control bit 1 = 0) counts from 0 to 0xFFFF_FFFF and sets the raw flag when it passes zero.
- R6: Periodic mode (control bit 1 = 1) takes the reload value after 0 and sets the raw flag. A reload write made while running takes effect at the next reload only.
- R7: Control bit 2 masks the channel. The interrupt line and the status word (bit 0) equal raw AND enabled AND NOT masked. The raw flag still sets while the channel is masked.
- R8: A read of a channel's acknowledge word returns 0 and clears only that channel's raw flag. A new zero crossing in the same cycle wins over the clear.
- R9: Offset 0xA0 returns the masked status of all channels (bit k = channel k) and 0xA8 returns their raw flags. A read of 0xA4 returns 0 and clears every raw flag.
- R10: Offset 0xAC returns the `VERSION` parameter.
- R11: Unmapped or misaligned offsets read 0 and ignore writes. The live count ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | APB and counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in the access phase |
| pready_o | output | 1 | Constant 1 |
| pslverr_o | output | 1 | Constant 0 |
| irq_o | output | N_TIMERS | Per-channel interrupt lines |

## Verification
The assertions assume well-formed APB: a setup cycle with `psel_i` high and `penable_i` low, then one access cycle, with address and data held across both. They also assume that `psel_i` never stays high with `penable_i` high past the access cycle, because each access cycle counts as one read and would clear again. The bench drives only through tasks that produce this two-cycle shape with an idle cycle in between. Its random phase limits reload values to small numbers so that zero crossings, wraps and reloads happen often within a short run.

// File: rtl/apb_tmr_pkg.sv
package apb_tmr_pkg;
  localparam int unsigned REG_STRIDE = 20;   // bytes per channel block
  localparam int unsigned N_FIELDS   = 5;
  localparam int unsigned N_GLOBAL   = 4;
  localparam int unsigned GLB_BASE   = 'hA0;

  localparam int unsigned F_LOAD = 0;
  localparam int unsigned F_CNT  = 1;
  localparam int unsigned F_CTRL = 2;
  localparam int unsigned F_ACK  = 3;
  localparam int unsigned F_STAT = 4;

  localparam int unsigned G_STAT = 0;
  localparam int unsigned G_ACK  = 1;
  localparam int unsigned G_RAW  = 2;
  localparam int unsigned G_VER  = 3;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_apb_decode.sv
module tmr_apb_decode
  import apb_tmr_pkg::*;
#(
  parameter int unsigned N_TIMERS = 4,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [N_TIMERS-1:0][N_FIELDS-1:0] ch_sel_o,
  output logic [N_GLOBAL-1:0]             glb_sel_o
);
  for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
      assign ch_sel_o[i][f] = (addr_i == ADDR_W'(i * REG_STRIDE + 4 * f));
    end
  end

  for (genvar g = 0; g < N_GLOBAL; g++) begin : g_glb
    assign glb_sel_o[g] = (addr_i == ADDR_W'(GLB_BASE + 4 * g));
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import apb_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_we_i,
  input  logic             ctrl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  tmr_ctrl_t        ctrl_wdata_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] count_o,
  output tmr_ctrl_t        ctrl_o,
  output logic             run_o,
  output logic             raw_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] load_q, count_q;
  tmr_ctrl_t        ctrl_q;
  logic             en_q, raw_q;
  logic             start, run, at_zero;

  assign start   = ctrl_q.en & ~en_q;
  assign run     = ctrl_q.en & en_q;
  assign at_zero = run & (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (load_we_i) load_q <= wdata_i;
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      en_q <= ctrl_q.en;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (start) begin
      count_q <= load_q;
    end else if (at_zero) begin
      count_q <= ctrl_q.periodic ? load_q : '1;
    end else if (run) begin
      count_q <= count_q - 1'b1;
    end
  end

  // zero crossing beats a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      raw_q <= 1'b0;
    else if (at_zero) raw_q <= 1'b1;
    else if (ack_i)   raw_q <= 1'b0;
  end

  assign load_o  = load_q;
  assign count_o = count_q;
  assign ctrl_o  = ctrl_q;
  assign run_o   = run;
  assign raw_o   = raw_q;
  assign irq_o   = raw_q & ctrl_q.en & ~ctrl_q.mask;
endmodule

// File: rtl/apb_timer_bank.sv
module apb_timer_bank
  import apb_tmr_pkg::*;
#(
  parameter int unsigned N_TIMERS = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] VERSION  = 32'h0001_0203
) (
  input  logic                pclk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [31:0]         pwdata_i,
  output logic [31:0]         prdata_o,
  output logic                pready_o,
  output logic                pslverr_o,
  output logic [N_TIMERS-1:0] irq_o
);
  logic [N_TIMERS-1:0][N_FIELDS-1:0] ch_sel;
  logic [N_GLOBAL-1:0]               glb_sel;
  logic                              wr_acc, rd_acc;

  logic [N_TIMERS-1:0][CNT_W-1:0] ch_load, ch_count;
  logic [N_TIMERS-1:0]            ch_en, ch_per, ch_mask, ch_run, ch_raw, ch_ack;
  logic [31:0]                    rdata;

  assign wr_acc = psel_i & penable_i & pwrite_i;
  assign rd_acc = psel_i & penable_i & ~pwrite_i;

  tmr_apb_decode #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (paddr_i),
    .ch_sel_o (ch_sel),
    .glb_sel_o(glb_sel)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    tmr_ctrl_t ctrl;
    assign ch_ack[i] = rd_acc & (ch_sel[i][F_ACK] | glb_sel[G_ACK]);

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i       (pclk_i),
      .rst_ni      (rst_ni),
      .load_we_i   (wr_acc & ch_sel[i][F_LOAD]),
      .ctrl_we_i   (wr_acc & ch_sel[i][F_CTRL]),
      .wdata_i     (pwdata_i[CNT_W-1:0]),
      .ctrl_wdata_i(tmr_ctrl_t'(pwdata_i[2:0])),
      .ack_i       (ch_ack[i]),
      .load_o      (ch_load[i]),
      .count_o     (ch_count[i]),
      .ctrl_o      (ctrl),
      .run_o       (ch_run[i]),
      .raw_o       (ch_raw[i]),
      .irq_o       (irq_o[i])
    );

    assign ch_en[i]   = ctrl.en;
    assign ch_per[i]  = ctrl.periodic;
    assign ch_mask[i] = ctrl.mask;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (ch_sel[i][F_LOAD]) rdata |= 32'(ch_load[i]);
      if (ch_sel[i][F_CNT])  rdata |= 32'(ch_count[i]);
      if (ch_sel[i][F_CTRL]) rdata |= {29'b0, ch_mask[i], ch_per[i], ch_en[i]};
      if (ch_sel[i][F_STAT]) rdata |= {31'b0, irq_o[i]};
    end
    if (glb_sel[G_STAT]) rdata |= 32'(irq_o);
    if (glb_sel[G_RAW])  rdata |= 32'(ch_raw);
    if (glb_sel[G_VER])  rdata |= VERSION;
  end

  assign prdata_o  = (psel_i & ~pwrite_i) ? rdata : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/tmr_bank_checks.sv
module tmr_bank_checks #(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     pready_i,
  input logic                     pslverr_i,
  input logic [N-1:0]             en_i,
  input logic [N-1:0]             per_i,
  input logic [N-1:0]             mask_i,
  input logic [N-1:0]             run_i,
  input logic [N-1:0]             raw_i,
  input logic [N-1:0]             ack_i,
  input logic [N-1:0]             irq_i,
  input logic [N-1:0][CNT_W-1:0]  load_i,
  input logic [N-1:0][CNT_W-1:0]  count_i
);
  assert_zero_wait_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_i && !pslverr_i);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_load_on_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_i[i]) |=> count_i[i] == $past(load_i[i]));

    assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[i] && count_i[i] != '0) |=> count_i[i] == CNT_W'($past(count_i[i]) - 1'b1));

    assert_hold_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[i] |=> $stable(count_i[i]));

    assert_quiet_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[i] |-> !irq_i[i]);

    assert_wrap_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[i] && count_i[i] == '0 && !per_i[i]) |=> (count_i[i] == '1) && raw_i[i]);

    assert_reload_periodic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[i] && count_i[i] == '0 && per_i[i]) |=> (count_i[i] == $past(load_i[i])) && raw_i[i]);

    assert_mask_gates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_i[i] |-> !irq_i[i]);

    assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[i] && !(run_i[i] && count_i[i] == '0)) |=> !raw_i[i]);
  end
endmodule

bind apb_timer_bank tmr_bank_checks #(.N(N_TIMERS), .CNT_W(CNT_W)) u_chk (
  .clk_i    (pclk_i),
  .rst_ni   (rst_ni),
  .pready_i (pready_o),
  .pslverr_i(pslverr_o),
  .en_i     (ch_en),
  .per_i    (ch_per),
  .mask_i   (ch_mask),
  .run_i    (ch_run),
  .raw_i    (ch_raw),
  .ack_i    (ch_ack),
  .irq_i    (irq_o),
  .load_i   (ch_load),
  .count_i  (ch_count)
);

// File: tb/tb_apb_timer_bank.sv
module tb_apb_timer_bank;
  localparam int N = 4;
  localparam logic [31:0] VER = 32'h0001_0203;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [N-1:0] irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  apb_timer_bank #(.N_TIMERS(N), .CNT_W(32), .ADDR_W(8), .VERSION(VER)) dut (
    .pclk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  // reference state, derived from the requirements
  logic [31:0] m_load [N];
  logic [31:0] m_cnt  [N];
  logic [2:0]  m_ctrl [N];
  logic        m_raw  [N];
  logic        m_enp  [N];

  function automatic bit hit(logic [7:0] a, int i, int f);
    return a == 8'(i * 20 + 4 * f);
  endfunction

  function automatic logic m_irq(int i);
    return m_raw[i] & m_ctrl[i][0] & ~m_ctrl[i][2];
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) begin
      if (hit(a, i, 0)) v = m_load[i];
      if (hit(a, i, 1)) v = m_cnt[i];
      if (hit(a, i, 2)) v = {29'b0, m_ctrl[i]};
      if (hit(a, i, 4)) v = {31'b0, m_irq(i)};
    end
    if (a == 8'hA0) for (int i = 0; i < N; i++) v[i] = m_irq(i);
    if (a == 8'hA8) for (int i = 0; i < N; i++) v[i] = m_raw[i];
    if (a == 8'hAC) v = VER;
    return v;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    for (int i = 0; i < N; i++) begin
      if (hit(a, i, 0)) return "R2";
      if (hit(a, i, 1)) return "R3";
      if (hit(a, i, 2) || hit(a, i, 4)) return "R7";
      if (hit(a, i, 3)) return "R8";
    end
    if (a == 8'hA0 || a == 8'hA4 || a == 8'hA8) return "R9";
    if (a == 8'hAC) return "R10";
    return "R11";
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        m_load[i] <= '0; m_cnt[i] <= '0; m_ctrl[i] <= '0;
        m_raw[i] <= 1'b0; m_enp[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (psel && penable && pwrite && hit(paddr, i, 0)) m_load[i] <= pwdata;
        if (psel && penable && pwrite && hit(paddr, i, 2)) m_ctrl[i] <= pwdata[2:0];
        m_enp[i] <= m_ctrl[i][0];
        if (m_ctrl[i][0] && !m_enp[i]) m_cnt[i] <= m_load[i];
        else if (m_ctrl[i][0] && m_cnt[i] == 0) m_cnt[i] <= m_ctrl[i][1] ? m_load[i] : 32'hFFFF_FFFF;
        else if (m_ctrl[i][0]) m_cnt[i] <= m_cnt[i] - 1;
        if (m_ctrl[i][0] && m_enp[i] && m_cnt[i] == 0) m_raw[i] <= 1'b1;
        else if (psel && penable && !pwrite && (hit(paddr, i, 3) || paddr == 8'hA4)) m_raw[i] <= 1'b0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // interrupt lines vs reference, every cycle (R7, R4)
  always @(negedge clk) begin
    if (mon_on) begin
      logic [N-1:0] e;
      for (int i = 0; i < N; i++) e[i] = m_irq(i);
      check("R7", 32'(irq), 32'(e));
    end
  end

  task automatic apb_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 check("R1", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(logic [7:0] a, string tag);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    check(tag, prdata, exp_read(a));
    check("R1", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    void'($urandom(32'd20240611));
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    mon_on = 1'b1;

    // reset state
    check("R2", 32'(irq), 32'h0);
    apb_read(8'h00, "R2"); apb_read(8'h04, "R2");
    apb_read(8'h08, "R2"); apb_read(8'h10, "R2");
    apb_read(8'hAC, "R10");
    check("R10", exp_read(8'hAC), 32'h0001_0203);
    apb_read(8'hA0, "R9"); apb_read(8'hA8, "R9");

    // channel 0 periodic, reload 5
    apb_write(8'h00, 32'd5);
    apb_read(8'h00, "R2");
    apb_write(8'h08, 32'h3);
    idle(2);
    apb_read(8'h04, "R3");
    idle(8);
    apb_read(8'h10, "R6");
    apb_read(8'h04, "R6");
    apb_read(8'h0C, "R8");
    apb_read(8'h10, "R8");

    // channel 1 free-running, reload 2
    apb_write(8'h14, 32'd2);
    apb_write(8'h1C, 32'h1);
    idle(6);
    apb_read(8'h18, "R5");
    apb_read(8'hA8, "R5");

    // channel 2 masked
    apb_write(8'h28, 32'd1);
    apb_write(8'h30, 32'h7);
    idle(5);
    apb_read(8'hA8, "R7");
    apb_read(8'hA0, "R7");
    apb_read(8'h38, "R7");

    // global acknowledge
    apb_read(8'hA4, "R9");
    apb_read(8'hA8, "R9");
    apb_read(8'h20, "R8");

    // channel 3 disabled hold
    apb_write(8'h3C, 32'd40);
    apb_write(8'h44, 32'h3);
    idle(3);
    apb_write(8'h44, 32'h2);
    apb_read(8'h40, "R4");
    idle(7);
    apb_read(8'h40, "R4");
    apb_read(8'h4C, "R4");

    // reload change while running on channel 0
    apb_write(8'h00, 32'd9);
    apb_read(8'h04, "R6");
    idle(12);
    apb_read(8'h04, "R6");

    // unmapped, misaligned and read-only
    apb_write(8'h64, 32'hFFFF_FFFF);
    apb_write(8'h50, 32'hFFFF_FFFF);
    apb_write(8'hB0, 32'h1234_5678);
    apb_read(8'h64, "R11"); apb_read(8'h50, "R11");
    apb_read(8'hB0, "R11"); apb_read(8'h01, "R11");
    check("R11", exp_read(8'hB0), 32'h0);
    apb_write(8'h04, 32'h1234);
    apb_read(8'h04, "R11");
    apb_write(8'h09, 32'h0);
    apb_read(8'h08, "R11");

    // random phase
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 9) < 8)
        a = 8'($urandom_range(0, N * 5 - 1) * 4 + ($urandom_range(0, 9) == 0 ? 0 : 0));
      else if ($urandom_range(0, 1) == 1)
        a = 8'hA0 + 8'($urandom_range(0, 3) * 4);
      else
        a = 8'($urandom_range(0, 255));
      // channel blocks are 20 bytes: remap the linear word index
      if (a < 8'(N * 20)) a = 8'((a / 4) / 5 * 20 + ((a / 4) % 5) * 4);
      if ($urandom_range(0, 1) == 1) begin
        if (((a % 20) == 0) && a < 8'(N * 20)) apb_write(a, 32'($urandom_range(0, 30)));
        else apb_write(a, $urandom);
      end else begin
        apb_read(a, tag_of(a));
      end
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 12));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule